// File: doc/BRIEF.md
# Aligned Load/Store Unit

This block carries out the byte, halfword and word loads and stores of a small processor against a private byte-addressed data memory. Each request gives a 32-bit base register value, a 16-bit displacement, an access size, a direction and, for stores, the register value to write. The unit adds the sign-extended displacement to the base to form the effective address. It then checks that address against the natural alignment of the access size, and only then touches the memory.

Loads return the fetched value zero-extended to 32 bits, ready for write-back to the destination register. Stores write the low 8, 16 or 32 bits of the source value, least significant byte at the lowest address. A misaligned halfword or word access raises a trap on the response. It writes nothing to memory and asks for no register write-back.

Every request is answered exactly one clock later by a single-cycle response strobe. A new request may be issued on every cycle. The memory is internal, holds 2^ADDR_W bytes, is not cleared by reset, and uses only the low ADDR_W bits of the effective address.

Top module: `lsu_top`

## Requirements
- R1: The effective address is req_base plus req_disp sign-extended from bit 15; only its low ADDR_W bits select a memory byte, so addresses wrap modulo 2^ADDR_W.
- R2: req_size encodes 0 = byte, 1 = halfword, 2 or 3 = word. A load that does not trap returns the 1, 2 or 4 bytes starting at the effective address, little-endian, zero-extended to 32 bits on rsp_data, with rsp_wb high.
- R3: A store that does not trap writes req_wdata[7:0] to the effective address, and for halfword and word sizes the next higher bytes of req_wdata to the next higher addresses. It leaves every other byte unchanged and never raises rsp_wb.
- R4: A halfword access whose effective address has bit 0 set raises rsp_trap.
- R5: A word access whose effective address has bit 1 or bit 0 set raises rsp_trap. Byte accesses never trap.
- R6: A trapped access writes no memory byte, keeps rsp_wb low and returns rsp_data = 0.
- R7: Each cycle with req_valid high is followed on the next cycle by exactly one cycle of rsp_ready high, carrying that request's trap, write-back and data. Without a request, rsp_ready, rsp_trap and rsp_wb stay low.
- R8: While rst_n is low, and on the first cycle after it rises, rsp_ready, rsp_trap, rsp_wb and rsp_data are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source value |
| rsp_ready | output | 1 | Response strobe, one cycle after a request |
| rsp_trap | output | 1 | Misaligned access trap |
| rsp_wb | output | 1 | Write-back request for a completed load |
| rsp_data | output | 32 | Zero-extended load value |

## Verification
A wrong byte-lane or address computation inside the unit is latent at the ports after a store. It only shows when a later load reads the corrupted bytes, one cycle after that load's request. For this reason, stores are always followed by word loads that cover neighbouring bytes as well. A wrong alignment decision or a stale response register shows up on the very next cycle, as a trap, a write-back flag or a ready strobe that does not match the request just made. A trapped store that still wrote memory is caught by reloading the target word immediately afterwards.

// File: rtl/lsu_pkg.sv
// Shared types and widths for the load/store unit.
// Assumes a 32-bit register file and byte-addressed memory.
package lsu_pkg;
    localparam int XLEN     = 32;
    localparam int DISP_W   = 16;
    localparam int LANES    = XLEN / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } lsu_size_e;

    // Byte-enable mask for a size, lane 0 is the lowest address.
    function automatic logic [LANES-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = 4'b0001;
            SZ_HALF: size_mask = 4'b0011;
            default: size_mask = 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/lsu_agen.sv
// Address generator: base plus sign-extended displacement, and alignment test.
// Purely combinational; assumes req_size encoding from lsu_pkg.
module lsu_agen
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        size,
    output logic [XLEN-1:0]   eff_addr,
    output logic              misaligned
);
    // Form the effective address.
    always_comb begin
        eff_addr = base + {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
    end

    // Flag accesses that break natural alignment for their size.
    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = eff_addr[0];
            default: misaligned = |eff_addr[1:0];
        endcase
    end
endmodule

// File: rtl/lsu_mem.sv
// Byte-array data memory with byte-lane synchronous write and registered
// 4-byte little-endian read. Contents are not reset. Addresses wrap.
module lsu_mem
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [LANES-1:0]   wr_mask,
    input  logic [XLEN-1:0]    wr_data,
    input  logic               rd_en,
    output logic [XLEN-1:0]    rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]        bytes_q [DEPTH];
    logic [ADDR_W-1:0] lane_addr [LANES];

    // One wrapped address per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_addr[g] = addr + ADDR_W'(g);
    end

    // Write enabled lanes on the clock edge.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wr_en && wr_mask[i]) begin
                bytes_q[lane_addr[i]] <= wr_data[8*i +: 8];
            end
        end
    end

    // Capture four consecutive bytes for a load.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            for (int i = 0; i < LANES; i++) begin
                rd_data[8*i +: 8] <= bytes_q[lane_addr[i]];
            end
        end
    end
endmodule

// File: rtl/lsu_extend.sv
// Zero-extends the raw 4-byte read to the access size.
// Combinational; lane 0 holds the byte at the effective address.
module lsu_extend
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0] raw,
    input  logic [1:0]      size,
    output logic [XLEN-1:0] value
);
    logic [LANES-1:0] keep;

    // Derive kept lanes from the size.
    always_comb keep = size_mask(size);

    // Clear every lane above the access width.
    for (genvar g = 0; g < LANES; g++) begin : g_ext
        assign value[8*g +: 8] = keep[g] ? raw[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/lsu_top.sv
// Aligned load/store unit. Accepts one request per cycle and responds one
// cycle later. Misaligned halfword/word accesses trap and are suppressed.
// Assumes synchronous active-low reset; memory content survives reset.
module lsu_top
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_store,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_base,
    input  logic [15:0] req_disp,
    input  logic [31:0] req_wdata,
    output logic        rsp_ready,
    output logic        rsp_trap,
    output logic        rsp_wb,
    output logic [31:0] rsp_data
);
    logic [XLEN-1:0] eff_addr;
    logic            misaligned;
    logic            go;
    logic [XLEN-1:0] raw_rd;
    logic [XLEN-1:0] ext_rd;

    logic            vld_q;
    logic            trap_q;
    logic            load_q;
    logic [1:0]      size_q;

    lsu_agen u_agen (
        .base       (req_base),
        .disp       (req_disp),
        .size       (req_size),
        .eff_addr   (eff_addr),
        .misaligned (misaligned)
    );

    // Only well-aligned requests reach the memory.
    always_comb go = req_valid && !misaligned;

    lsu_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .addr    (eff_addr[ADDR_W-1:0]),
        .wr_en   (go && req_store),
        .wr_mask (size_mask(req_size)),
        .wr_data (req_wdata),
        .rd_en   (go && !req_store),
        .rd_data (raw_rd)
    );

    // Register request attributes for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            trap_q <= 1'b0;
            load_q <= 1'b0;
            size_q <= SZ_BYTE;
        end else begin
            vld_q  <= req_valid;
            trap_q <= req_valid && misaligned;
            load_q <= req_valid && !req_store;
            size_q <= req_size;
        end
    end

    lsu_extend u_ext (
        .raw   (raw_rd),
        .size  (size_q),
        .value (ext_rd)
    );

    // Drive the response from the registered state.
    always_comb begin
        rsp_ready = vld_q;
        rsp_trap  = vld_q && trap_q;
        rsp_wb    = vld_q && load_q && !trap_q;
        rsp_data  = rsp_wb ? ext_rd : '0;
    end
endmodule

// File: rtl/lsu_checker.sv
// Property checker for lsu_top, attached by bind below.
module lsu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_store,
    input logic [1:0]  req_size,
    input logic [31:0] req_base,
    input logic [15:0] req_disp,
    input logic        rsp_ready,
    input logic        rsp_trap,
    input logic        rsp_wb,
    input logic [31:0] rsp_data
);
    logic [1:0] low_sum;
    assign low_sum = req_base[1:0] + req_disp[1:0];

    a_r7_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_ready && !rsp_trap && !rsp_wb));

    a_r6_trap_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (!rsp_wb && rsp_data == 32'h0));

    a_r3_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store) |=> !rsp_wb);

    a_r4_half_odd_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd1 && low_sum[0]) |=> rsp_trap);

    a_r5_word_misaligned_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size[1] && low_sum != 2'd0) |=> rsp_trap);

    a_r5_byte_never_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |=> !rsp_trap);

    a_r2_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_size == 2'd0) |=> rsp_data[31:8] == 24'h0);
endmodule

bind lsu_top lsu_checker u_lsu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .req_size  (req_size),
    .req_base  (req_base),
    .req_disp  (req_disp),
    .rsp_ready (rsp_ready),
    .rsp_trap  (rsp_trap),
    .rsp_wb    (rsp_wb),
    .rsp_data  (rsp_data)
);

// File: tb/tb_lsu_top.sv
// Self-checking bench: vector table walked back-to-back, then directed tests.
module tb_lsu_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;
    // {store, size, base, disp, wdata, exp_trap, exp_data}
    localparam logic [115:0] VEC [NVEC] = '{
        {1'b1, 2'd2, 32'h0000_0010, 16'h0000, 32'h1122_3344, 1'b0, 32'h0},          // R3 word store
        {1'b0, 2'd2, 32'h0000_0010, 16'h0000, 32'h0, 1'b0, 32'h1122_3344},           // R2 word load
        {1'b0, 2'd0, 32'h0000_0010, 16'h0001, 32'h0, 1'b0, 32'h0000_0033},           // R2 byte load
        {1'b0, 2'd1, 32'h0000_0014, 16'hFFFE, 32'h0, 1'b0, 32'h0000_1122},           // R1 negative disp
        {1'b1, 2'd0, 32'h0000_0010, 16'h0003, 32'hAABB_CCF0, 1'b0, 32'h0},           // R3 byte store
        {1'b0, 2'd2, 32'h0000_0010, 16'h0000, 32'h0, 1'b0, 32'hF022_3344},           // R3 one lane only
        {1'b1, 2'd1, 32'h0000_0011, 16'h0000, 32'h5555_5555, 1'b1, 32'h0},           // R4 odd half store
        {1'b0, 2'd2, 32'h0000_0010, 16'h0000, 32'h0, 1'b0, 32'hF022_3344},           // R6 no write
        {1'b1, 2'd2, 32'h0000_0012, 16'h0000, 32'h9999_9999, 1'b1, 32'h0},           // R5 bit1 word store
        {1'b0, 2'd2, 32'h0000_0013, 16'h0000, 32'h0, 1'b1, 32'h0},                   // R5/R6 word load trap
        {1'b0, 2'd2, 32'h0000_000F, 16'h0001, 32'h0, 1'b0, 32'hF022_3344},           // R1 aligned via disp
        {1'b0, 2'd1, 32'h0000_0010, 16'h0001, 32'h0, 1'b1, 32'h0},                   // R4 half load trap
        {1'b1, 2'd2, 32'h0000_0020, 16'h0000, 32'hFFFF_FFFF, 1'b0, 32'h0},           // R3 fill
        {1'b1, 2'd1, 32'h0000_0020, 16'h0000, 32'h1234_8899, 1'b0, 32'h0},           // R3 half store
        {1'b0, 2'd2, 32'h0000_0020, 16'h0000, 32'h0, 1'b0, 32'hFFFF_8899},           // R3 two lanes
        {1'b0, 2'd1, 32'h0000_0022, 16'h0000, 32'h0, 1'b0, 32'h0000_FFFF},           // R2 half zero-ext
        {1'b0, 2'd2, 32'hFFFF_FFF0, 16'h0020, 32'h0, 1'b0, 32'hF022_3344},           // R1 wrap
        {1'b0, 2'd0, 32'h0000_0111, 16'h0000, 32'h0, 1'b0, 32'h0000_0033}            // R1/R5 byte odd
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_base = '0;
    logic [15:0] req_disp = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ready, rsp_trap, rsp_wb;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_top #(.ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_base(req_base), .req_disp(req_disp),
        .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_trap(rsp_trap),
        .rsp_wb(rsp_wb), .rsp_data(rsp_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic st, input logic [1:0] sz,
                         input logic [31:0] b, input logic [15:0] d, input logic [31:0] w);
        req_valid = v; req_store = st; req_size = sz;
        req_base = b; req_disp = d; req_wdata = w;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R8: reset holds the response idle even with a request present.
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd2, 32'h0, 16'h0, 32'h0);
        repeat (3) @(negedge clk);
        check("R8 ready in reset", {31'b0, rsp_ready}, 32'h0);
        check("R8 trap in reset", {31'b0, rsp_trap}, 32'h0);
        check("R8 wb in reset", {31'b0, rsp_wb}, 32'h0);
        check("R8 data in reset", rsp_data, 32'h0);
        drive(1'b0, 1'b0, 2'd0, 32'h0, 16'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 ready after reset", {31'b0, rsp_ready}, 32'h0);
        check("R8 data after reset", rsp_data, 32'h0);

        // Vector table, one request per cycle, response checked next cycle.
        for (int k = 0; k < NVEC; k++) begin
            logic [115:0] v;
            v = VEC[k];
            drive(1'b1, v[115], v[114:113], v[112:81], v[80:65], v[64:33]);
            @(negedge clk);
            check($sformatf("R7 ready vec%0d", k), {31'b0, rsp_ready}, 32'h1);
            check($sformatf("R4/R5 trap vec%0d", k), {31'b0, rsp_trap}, {31'b0, v[32]});
            check($sformatf("R2/R6 wb vec%0d", k), {31'b0, rsp_wb},
                  {31'b0, (!v[115] && !v[32])});
            check($sformatf("R1/R2/R3 data vec%0d", k), rsp_data, v[31:0]);
        end

        // R7: idle cycle gives no response.
        drive(1'b0, 1'b0, 2'd0, 32'h0, 16'h0, 32'h0);
        @(negedge clk);
        check("R7 idle ready", {31'b0, rsp_ready}, 32'h0);
        check("R7 idle wb", {31'b0, rsp_wb}, 32'h0);

        // R7: single request gives exactly one strobe.
        drive(1'b1, 1'b0, 2'd0, 32'h10, 16'h0, 32'h0);
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 32'h0, 16'h0, 32'h0);
        check("R7 single strobe", {31'b0, rsp_ready}, 32'h1);
        check("R2 byte at 0x10", rsp_data, 32'h0000_0044);
        @(negedge clk);
        check("R7 strobe ends", {31'b0, rsp_ready}, 32'h0);

        // R6: trapped word store at wrapped misaligned address leaves memory intact.
        drive(1'b1, 1'b1, 2'd3, 32'h0000_0111, 16'h0000, 32'h0);
        @(negedge clk);
        check("R5 size3 word trap", {31'b0, rsp_trap}, 32'h1);
        drive(1'b1, 1'b0, 2'd2, 32'h0000_0010, 16'h0000, 32'h0);
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 32'h0, 16'h0, 32'h0);
        check("R6 memory unchanged", rsp_data, 32'hF022_3344);

        // R8: reset mid-stream clears a pending response.
        drive(1'b1, 1'b0, 2'd2, 32'h10, 16'h0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset clears ready", {31'b0, rsp_ready}, 32'h0);
        drive(1'b0, 1'b0, 2'd0, 32'h0, 16'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule